// File: doc/BRIEF.md
# Interrupt Group to FIQ/IRQ Router with Security-Disable Control

This block sits in front of one processor core. It takes the tag of the interrupt that currently wins arbitration and drives one of two interrupt lines, the fast line (FIQ) or the normal line (IRQ). The tag names one of three groups: Group 0, Secure Group 1 or Non-secure Group 1. Which line a tag selects depends on the security state the core is in. Both lines are registered, so they follow the inputs one clock later.

A small register port holds the block's configuration. Every access carries a secure/non-secure attribute. A control register holds a security-disable bit and one enable bit per group. While security is disabled, the block behaves as if there were only one security state and two groups, and software at any privilege level may program it. A separate lock register holds a sticky lock bit, which only a secure access can set. Once the lock is set, the security-disable bit can no longer change, and only a hardware reset clears the lock. A build parameter can tie the security-disable bit to 1 permanently.

The security-disable bit and the lock bit live together in a four-state mode machine:
- MODE_SEC: security is on and the lock is clear. Reset enters this state unless the parameter forces security-disable.
- MODE_FLAT: security is disabled and the lock is clear.
- MODE_SEC_LOCK: security is on and the lock is set.
- MODE_FLAT_LOCK: security is disabled and the lock is set.

The machine has four transitions:
- T_ENTER_FLAT: MODE_SEC to MODE_FLAT, on a secure control write with bit 0 set.
- T_LEAVE_FLAT: MODE_FLAT to MODE_SEC, on any control write with bit 0 clear. This transition does not exist when the parameter forces security-disable.
- T_LOCK_SEC: MODE_SEC to MODE_SEC_LOCK, on a secure lock write with bit 0 set.
- T_LOCK_FLAT: MODE_FLAT to MODE_FLAT_LOCK, on a secure lock write with bit 0 set.

The two locked states have no way out except reset.

Top module: `irq_group_router`

## Requirements
- R1: The group tag is encoded as 2'b00 for Group 0, 2'b01 for Secure Group 1 and 2'b10 for Non-secure Group 1. With security on and the core secure, Group 0 drives FIQ, Secure Group 1 drives IRQ and Non-secure Group 1 drives FIQ.
- R2: With security on and the core non-secure, Group 0 drives FIQ, Secure Group 1 drives FIQ and Non-secure Group 1 drives IRQ.
- R3: With security disabled, Group 0 drives FIQ, and both tag 2'b01 and tag 2'b10 drive IRQ, whatever the core's state. In this mode the single Group 1 is enabled by control bit 3.
- R4: Both lines stay low in each of these cases: nothing is pending, the tag is 2'b11, or the pending group's enable bit is clear. The enable bits are control bit 1 for Group 0, bit 2 for Secure Group 1 and bit 3 for Non-secure Group 1.
- R5: FIQ and IRQ are registered and change one cycle after their inputs. A control write in the same cycle as a pending interrupt does not change the mode used for that cycle's routing. The new mode applies from the following cycle.
- R6: The control register is at offset 0, with bit 0 as the security-disable bit and bits 1 to 3 as the enables. Read data appears one cycle after the read strobe. A secure write reads back unchanged.
- R7: While security is on, a non-secure control write changes only bit 3, and a non-secure control read shows only bit 3. A non-secure write to the security-disable bit or to the lock bit is ignored, and a non-secure read of the lock register returns 0.
- R8: While security is disabled, a non-secure access may write every control bit, including clearing the security-disable bit.
- R9: The lock bit is bit 0 at offset 1 and only a secure access can set it. Once it is set, writes to the security-disable bit are ignored, while the enable bits stay writable.
- R10: Writing 0 to the lock bit does not clear it. Only reset does.
- R11: When the parameter DS_FORCED is 1, the security-disable bit reads 1 from reset and writes of 0 to it are ignored.
- R12: After reset, the control and lock registers read 0 and both lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register offset (0 is control, 1 is lock) |
| reg_wdata | input | DATA_W | Write data |
| reg_secure | input | 1 | 1 when the access is secure |
| reg_rdata | output | DATA_W | Read data, valid one cycle after reg_rd_en |
| core_secure | input | 1 | 1 when the core is in the secure state |
| pend_valid | input | 1 | An interrupt is pending |
| pend_group | input | 2 | Group tag of the pending interrupt |
| fiq_o | output | 1 | Fast interrupt line |
| irq_o | output | 1 | Normal interrupt line |

## Verification
A control write that flips the security-disable bit can land in the same cycle that the output register samples a pending interrupt. The bench provokes this with a non-secure core and a Secure Group 1 interrupt held pending, then issues the write in exactly that cycle. For this tag and core state the two modes choose different lines. The line seen one cycle later must still follow the old mode (FIQ), and the line seen the cycle after that must follow the new mode (IRQ). A lock write and a security-disable write meet in the same way across consecutive cycles. That case is judged by reading back the control register after the lock has been set.

// File: rtl/sgr_pkg.sv
package sgr_pkg;

    typedef enum logic [1:0] {
        MODE_SEC       = 2'd0,
        MODE_FLAT      = 2'd1,
        MODE_SEC_LOCK  = 2'd2,
        MODE_FLAT_LOCK = 2'd3
    } sec_mode_e;

    typedef enum logic [1:0] {
        GRP_G0   = 2'b00,
        GRP_G1S  = 2'b01,
        GRP_G1NS = 2'b10,
        GRP_BAD  = 2'b11
    } grp_tag_e;

    localparam int CB_DS     = 0;
    localparam int CB_G0     = 1;
    localparam int CB_G1S    = 2;
    localparam int CB_G1NS   = 3;
    localparam int CTRL_USED = 4;
    localparam int LB_DSL    = 0;

endpackage

// File: rtl/sgr_mode_fsm.sv
module sgr_mode_fsm
    import sgr_pkg::*;
#(
    parameter bit DS_FORCED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic wr_lock,
    input  logic acc_secure,
    input  logic wbit_ds,
    input  logic wbit_dsl,
    output logic ds,
    output logic dsl
);

    localparam sec_mode_e RST_MODE = DS_FORCED ? MODE_FLAT : MODE_SEC;

    sec_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SEC: begin
                if (wr_lock && acc_secure && wbit_dsl)
                    state_d = MODE_SEC_LOCK;            // T_LOCK_SEC
                else if (wr_ctrl && acc_secure && wbit_ds)
                    state_d = MODE_FLAT;                // T_ENTER_FLAT
            end
            MODE_FLAT: begin
                if (wr_lock && acc_secure && wbit_dsl)
                    state_d = MODE_FLAT_LOCK;           // T_LOCK_FLAT
                else if (wr_ctrl && !wbit_ds && !DS_FORCED)
                    state_d = MODE_SEC;                 // T_LEAVE_FLAT
            end
            MODE_SEC_LOCK:  state_d = MODE_SEC_LOCK;
            MODE_FLAT_LOCK: state_d = MODE_FLAT_LOCK;
            default:        state_d = RST_MODE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_MODE;
        else        state_q <= state_d;
    end

    always_comb begin
        ds  = (state_q == MODE_FLAT) || (state_q == MODE_FLAT_LOCK);
        dsl = (state_q == MODE_SEC_LOCK) || (state_q == MODE_FLAT_LOCK);
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dsl |=> dsl);                                                   // R10
    AST_DS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        dsl |=> $stable(ds));                                           // R9
    AST_NS_LOCK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && !acc_secure) |=> $stable(dsl));                     // R9
    AST_NS_DS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !acc_secure && !ds) |=> !ds);                       // R7
    AST_FORCED_DS: assert property (@(posedge clk) disable iff (!rst_n)
        (DS_FORCED != 1'b0) |-> ds);                                    // R11

endmodule

// File: rtl/sgr_cfg_regs.sv
module sgr_cfg_regs
    import sgr_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int CTRL_OFS = 0,
    parameter int LOCK_OFS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              acc_secure,
    input  logic              ds,
    input  logic              dsl,
    output logic              wr_ctrl,
    output logic              wr_lock,
    output logic              en_g0,
    output logic              en_g1s,
    output logic              en_g1ns,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_OFS);

    logic              hit_ctrl, hit_lock, full_view;
    logic [DATA_W-1:0] ctrl_view, lock_view;
    logic              unused_wbits;

    assign unused_wbits = ^{wdata[DATA_W-1:CTRL_USED], wdata[CB_DS]};

    always_comb begin
        hit_ctrl  = (addr == CTRL_A);
        hit_lock  = (addr == LOCK_A);
        wr_ctrl   = wr_en && hit_ctrl;
        wr_lock   = wr_en && hit_lock;
        full_view = ds || acc_secure;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_g0   <= 1'b0;
            en_g1s  <= 1'b0;
            en_g1ns <= 1'b0;
        end else if (wr_ctrl) begin
            en_g1ns <= wdata[CB_G1NS];
            if (full_view) begin
                en_g0  <= wdata[CB_G0];
                en_g1s <= wdata[CB_G1S];
            end
        end
    end

    always_comb begin
        ctrl_view = '0;
        lock_view = '0;
        ctrl_view[CB_G1NS] = en_g1ns;
        if (full_view) begin
            ctrl_view[CB_DS]  = ds;
            ctrl_view[CB_G0]  = en_g0;
            ctrl_view[CB_G1S] = en_g1s;
            lock_view[LB_DSL] = dsl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  rdata <= '0;
        else if (rd_en && hit_ctrl)  rdata <= ctrl_view;
        else if (rd_en && hit_lock)  rdata <= lock_view;
        else                         rdata <= '0;
    end

    AST_NS_ENABLE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !acc_secure && !ds) |=> ($stable(en_g0) && $stable(en_g1s))); // R7

endmodule

// File: rtl/sgr_route.sv
module sgr_route
    import sgr_pkg::*;
(
    input  logic       pend_valid,
    input  logic [1:0] pend_group,
    input  logic       core_secure,
    input  logic       ds,
    input  logic       en_g0,
    input  logic       en_g1s,
    input  logic       en_g1ns,
    output logic       fiq_n,
    output logic       irq_n
);

    grp_tag_e tag;

    always_comb begin
        tag   = grp_tag_e'(pend_group);
        fiq_n = 1'b0;
        irq_n = 1'b0;
        if (pend_valid) begin
            unique case (tag)
                GRP_G0: fiq_n = en_g0;
                GRP_G1S: begin
                    if (ds)               irq_n = en_g1ns;
                    else if (core_secure) irq_n = en_g1s;
                    else                  fiq_n = en_g1s;
                end
                GRP_G1NS: begin
                    if (ds || !core_secure) irq_n = en_g1ns;
                    else                    fiq_n = en_g1ns;
                end
                GRP_BAD: begin
                    fiq_n = 1'b0;
                    irq_n = 1'b0;
                end
                default: begin
                    fiq_n = 1'b0;
                    irq_n = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_group_router.sv
module irq_group_router
    import sgr_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int CTRL_OFS  = 0,
    parameter int LOCK_OFS  = 1,
    parameter bit DS_FORCED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_secure,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              core_secure,
    input  logic              pend_valid,
    input  logic [1:0]        pend_group,
    output logic              fiq_o,
    output logic              irq_o
);

    logic ds, dsl, wr_ctrl, wr_lock;
    logic en_g0, en_g1s, en_g1ns;
    logic fiq_n, irq_n;

    sgr_mode_fsm #(.DS_FORCED(DS_FORCED)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_lock    (wr_lock),
        .acc_secure (reg_secure),
        .wbit_ds    (reg_wdata[CB_DS]),
        .wbit_dsl   (reg_wdata[LB_DSL]),
        .ds         (ds),
        .dsl        (dsl)
    );

    sgr_cfg_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CTRL_OFS (CTRL_OFS),
        .LOCK_OFS (LOCK_OFS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .rd_en      (reg_rd_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .acc_secure (reg_secure),
        .ds         (ds),
        .dsl        (dsl),
        .wr_ctrl    (wr_ctrl),
        .wr_lock    (wr_lock),
        .en_g0      (en_g0),
        .en_g1s     (en_g1s),
        .en_g1ns    (en_g1ns),
        .rdata      (reg_rdata)
    );

    sgr_route u_route (
        .pend_valid  (pend_valid),
        .pend_group  (pend_group),
        .core_secure (core_secure),
        .ds          (ds),
        .en_g0       (en_g0),
        .en_g1s      (en_g1s),
        .en_g1ns     (en_g1ns),
        .fiq_n       (fiq_n),
        .irq_n       (irq_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fiq_o <= 1'b0;
            irq_o <= 1'b0;
        end else begin
            fiq_o <= fiq_n;
            irq_o <= irq_n;
        end
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid |=> (!fiq_o && !irq_o));                                    // R4
    AST_G0_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && pend_group == 2'b00 && en_g0) |=> fiq_o);                // R1
    AST_NS_G1NS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && pend_group == 2'b10 && !core_secure && en_g1ns) |=> irq_o); // R2
    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fiq_o && irq_o));                                                     // R3

endmodule

// File: tb/sim_irq_group_router.sv
`timescale 1ns/1ps
module sim_irq_group_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, acc_sec = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        core_sec = 1'b0, pvalid = 1'b0;
    logic [1:0]  pgrp = 2'b00;
    logic [31:0] rdata0, rdata1;
    logic        fiq0, irq0, fiq1, irq1;
    int          total = 0, bad = 0;
    logic [31:0] v0, v1;

    always #10 clk = ~clk;

    irq_group_router #(.DS_FORCED(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
        .reg_addr(addr), .reg_wdata(wdata), .reg_secure(acc_sec), .reg_rdata(rdata0),
        .core_secure(core_sec), .pend_valid(pvalid), .pend_group(pgrp),
        .fiq_o(fiq0), .irq_o(irq0));

    irq_group_router #(.DS_FORCED(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
        .reg_addr(addr), .reg_wdata(wdata), .reg_secure(acc_sec), .reg_rdata(rdata1),
        .core_secure(core_sec), .pend_valid(pvalid), .pend_group(pgrp),
        .fiq_o(fiq1), .irq_o(irq1));

    // fields: req[17:14] ds[9] sec[8] valid[7] grp[6:5] en{g1ns,g1s,g0}[4:2] fiq[1] irq[0]
    localparam logic [17:0] VEC [13] = '{
        {4'd1, 4'd0, 1'b0, 1'b1, 1'b1, 2'b00, 3'b111, 2'b10}, // R1
        {4'd1, 4'd0, 1'b0, 1'b1, 1'b1, 2'b01, 3'b111, 2'b01}, // R1
        {4'd1, 4'd0, 1'b0, 1'b1, 1'b1, 2'b10, 3'b111, 2'b10}, // R1
        {4'd2, 4'd0, 1'b0, 1'b0, 1'b1, 2'b00, 3'b111, 2'b10}, // R2
        {4'd2, 4'd0, 1'b0, 1'b0, 1'b1, 2'b01, 3'b111, 2'b10}, // R2
        {4'd2, 4'd0, 1'b0, 1'b0, 1'b1, 2'b10, 3'b111, 2'b01}, // R2
        {4'd3, 4'd0, 1'b1, 1'b1, 1'b1, 2'b01, 3'b100, 2'b01}, // R3
        {4'd3, 4'd0, 1'b1, 1'b0, 1'b1, 2'b10, 3'b100, 2'b01}, // R3
        {4'd3, 4'd0, 1'b1, 1'b0, 1'b1, 2'b00, 3'b001, 2'b10}, // R3
        {4'd4, 4'd0, 1'b0, 1'b1, 1'b0, 2'b00, 3'b111, 2'b00}, // R4
        {4'd4, 4'd0, 1'b0, 1'b1, 1'b1, 2'b11, 3'b111, 2'b00}, // R4
        {4'd4, 4'd0, 1'b0, 1'b0, 1'b1, 2'b10, 3'b011, 2'b00}, // R4
        {4'd4, 4'd0, 1'b1, 1'b1, 1'b1, 2'b01, 3'b011, 2'b00}  // R4
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic s);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; acc_sec = s;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic s,
                      output logic [31:0] r0, output logic [31:0] r1);
        @(negedge clk);
        rd_en = 1'b1; addr = a; acc_sec = s;
        @(negedge clk);
        r0 = rdata0; r1 = rdata1;
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pvalid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        check("R12", "fiq after reset", {31'b0, fiq0}, 32'd0);
        check("R12", "irq after reset", {31'b0, irq0}, 32'd0);
        rd(4'd0, 1'b1, v0, v1);
        check("R12", "ctrl after reset", v0, 32'h0);
        rd(4'd1, 1'b1, v0, v1);
        check("R12", "lock after reset", v0, 32'h0);

        // routing vector table
        for (int i = 0; i < 13; i++) begin
            logic [17:0] v;
            v = VEC[i];
            wr(4'd0, {28'b0, v[4:2], v[9]}, 1'b1);
            core_sec = v[8]; pvalid = v[7]; pgrp = v[6:5];
            @(negedge clk);
            check($sformatf("R%0d", v[17:14]), $sformatf("vector %0d fiq/irq", i),
                  {30'b0, fiq0, irq0}, {30'b0, v[1:0]});
        end
        pvalid = 1'b0;

        // R6 control layout and readback
        wr(4'd0, 32'hF, 1'b1);
        rd(4'd0, 1'b1, v0, v1);
        check("R6", "secure readback 0xF", v0, 32'hF);
        wr(4'd0, 32'h6, 1'b1);
        rd(4'd0, 1'b1, v0, v1);
        check("R6", "secure readback 0x6", v0, 32'h6);

        // R7 non-secure restrictions with security on
        wr(4'd0, 32'hF, 1'b0);
        rd(4'd0, 1'b1, v0, v1);
        check("R7", "ns write changes only bit3", v0, 32'hE);
        rd(4'd0, 1'b0, v0, v1);
        check("R7", "ns read shows only bit3", v0, 32'h8);
        wr(4'd1, 32'h1, 1'b0);
        rd(4'd1, 1'b1, v0, v1);
        check("R7", "ns lock write ignored", v0, 32'h0);
        rd(4'd1, 1'b0, v0, v1);
        check("R7", "ns lock read zero", v0, 32'h0);

        // R5 registered output and same-cycle mode change
        wr(4'd0, 32'hE, 1'b1);
        core_sec = 1'b0; pvalid = 1'b1; pgrp = 2'b01;
        @(negedge clk);
        check("R5", "secure group1 on ns core before write", {30'b0, fiq0, irq0}, 32'b10);
        wr_en = 1'b1; addr = 4'd0; wdata = 32'hF; acc_sec = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R5", "same-cycle write uses old mode", {30'b0, fiq0, irq0}, 32'b10);
        @(negedge clk);
        check("R5", "new mode next cycle", {30'b0, fiq0, irq0}, 32'b01);
        pgrp = 2'b00;
        check("R5", "no combinational path", {30'b0, fiq0, irq0}, 32'b01);
        @(negedge clk);
        check("R5", "one-cycle latency", {30'b0, fiq0, irq0}, 32'b10);
        pvalid = 1'b0;

        // R8 non-secure writes in flat mode
        wr(4'd0, 32'h2, 1'b0);
        rd(4'd0, 1'b1, v0, v1);
        check("R8", "ns write clears DS", v0, 32'h2);

        // R9 lock in flat mode
        wr(4'd0, 32'hF, 1'b1);
        wr(4'd1, 32'h1, 1'b1);
        rd(4'd1, 1'b1, v0, v1);
        check("R9", "lock set by secure", v0, 32'h1);
        wr(4'd0, 32'h0, 1'b1);
        rd(4'd0, 1'b1, v0, v1);
        check("R9", "DS frozen, enables writable", v0, 32'h1);

        // R10 sticky lock
        wr(4'd1, 32'h0, 1'b1);
        rd(4'd1, 1'b1, v0, v1);
        check("R10", "lock not cleared by write", v0, 32'h1);
        do_reset();
        rd(4'd1, 1'b1, v0, v1);
        check("R10", "lock cleared by reset", v0, 32'h0);
        rd(4'd0, 1'b1, v0, v1);
        check("R10", "ctrl cleared by reset", v0, 32'h0);

        // R9 lock with security on
        wr(4'd1, 32'h1, 1'b1);
        wr(4'd0, 32'h1, 1'b1);
        rd(4'd0, 1'b1, v0, v1);
        check("R9", "DS cannot be set while locked", v0, 32'h0);

        // R11 forced security-disable instance
        do_reset();
        rd(4'd0, 1'b1, v0, v1);
        check("R11", "forced DS at reset", v1, 32'h1);
        wr(4'd0, 32'h8, 1'b1);
        wr(4'd0, 32'h0, 1'b0);
        rd(4'd0, 1'b1, v0, v1);
        check("R11", "DS write of 0 ignored", v1, 32'h1);
        wr(4'd0, 32'h8, 1'b1);
        core_sec = 1'b1; pvalid = 1'b1; pgrp = 2'b01;
        @(negedge clk);
        check("R11", "forced flat routing", {30'b0, fiq1, irq1}, 32'b01);
        pvalid = 1'b0;

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule